// File: doc/BRIEF.md
# Pulse-Height Readout Sequencer and Serializer

This block runs the digital side of one readout cycle for a photodetector front end that holds its pulse heights on a common hold strobe. When the hold is seen and the sequencer is idle, it takes a snapshot of a source-enable mask and of a bit-rate divide ratio. It then selects each enabled source on an analog multiplexer, one after another, and starts a 12-bit successive-approximation converter through a start/done handshake. Each result goes out on a single serial line as a framed word that carries the source index, so the receiver never has to work out which source a word belongs to.

There are nineteen sources, and mask bit i enables source i. Indices 0 to 15 are the detector channels, index 16 is the summing channel, and indices 17 and 18 are the two auxiliary analog inputs. Disabled sources cost no conversion and no serial time. Once the last frame has gone out, the block raises a one-cycle front-end reset that releases the hold and re-arms the channels, and it then returns to idle. A hold that arrives during a cycle is ignored.

Top module: `rdo_seq`

## Requirements
- R1: When the block is idle, a high `hold_i` at a clock edge starts a cycle. `busy_o` is high from the next cycle on, and `src_mask_i` and `baud_div_i` are captured at that edge.
- R2: Only sources whose mask bit is set are converted, each exactly once, in ascending index order. The number of `adc_start_o` pulses equals the number of set mask bits.
- R3: While `adc_start_o` is high and until `adc_done_i` is taken, `mux_sel_o` holds the index of the source being converted and `mux_en_o` is high.
- R4: `ser_o` is high (line idle) whenever no frame bit is being sent, and in particular whenever `busy_o` is low.
- R5: `adc_start_o` is a one-cycle pulse. The sequencer then waits for `adc_done_i` for as long as it takes and captures `adc_data_i` in the cycle where done is high.
- R6: Every frame is 19 bits in this order on the line: a start bit of 0, the 5-bit source index MSB first, the 12 data bits MSB first, and a stop bit of 1.
- R7: Each frame bit lasts `baud_div_i`+1 clock cycles, using the ratio captured at the hold.
- R8: The start bit begins in the cycle after `adc_done_i` is sampled. The first conversion starts two cycles after the hold edge, so with a converter that answers 18 cycles after it sees start, the first start bit appears 21 cycles after the hold.
- R9: After the last frame, `fe_reset_o` is high for exactly one cycle while `busy_o` is still high, and `busy_o` is low in the next cycle. An all-zero mask gives this reset with no conversion at all.
- R10: A `hold_i` while `busy_o` is high is ignored. It adds no frame, no conversion and no extra reset, and it does not change the captured mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also times the serial line |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Hold strobe that starts a readout cycle |
| src_mask_i | input | 19 | Source enable mask, bit i enables source i |
| baud_div_i | input | 8 | Serial bit length minus one, in clock cycles |
| mux_sel_o | output | 5 | Analog multiplexer source index |
| mux_en_o | output | 1 | Multiplexer enable during a conversion |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_done_i | input | 1 | Conversion done strobe |
| adc_data_i | input | 12 | Conversion result, valid with done |
| ser_o | output | 1 | Serial data line, idle high |
| busy_o | output | 1 | High from hold acceptance to end of cycle |
| fe_reset_o | output | 1 | One-cycle front-end reset ending the cycle |

## Verification
A wrong scan pointer or a corrupted captured mask shows up within one frame time. The index field of the next frame names the wrong source, or the number of converter starts stops matching the mask. A slipped bit or divide counter shifts the sampling point of the bench receiver, so the same frame comes in with a bad stop bit or bad data. A sequencer stuck after the last source never raises the reset, and the bench sees this within a few thousand cycles. A retriggered cycle shows up as an extra reset pulse or as extra frames.

// File: rtl/rdo_seq_pkg.sv
package rdo_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_START,
      ST_WAIT,
      ST_SHIFT,
      ST_FIN
   } seq_state_e;
endpackage

// File: rtl/rdo_src_pick.sv
// Lowest-pending-source finder: one-hot isolation then index encode.
module rdo_src_pick #(
   parameter int N_SRC = 19,
   parameter int IDX_W = 5
) (
   input  logic [N_SRC-1:0] pend_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N_SRC-1:0] onehot_o
);
   logic [IDX_W-1:0] part [N_SRC];

   assign any_o    = |pend_i;
   assign onehot_o = pend_i & (~pend_i + N_SRC'(1));

   for (genvar g = 0; g < N_SRC; g++) begin : g_enc
      if (g == 0) begin : g_first
         assign part[g] = '0;
      end else begin : g_rest
         assign part[g] = part[g-1] | (onehot_o[g] ? IDX_W'(g) : '0);
      end
   end

   assign idx_o = part[N_SRC-1];
endmodule

// File: rtl/rdo_frame_tx.sv
// Frame shifter with a programmable bit length.
module rdo_frame_tx #(
   parameter int FRAME_W = 19,
   parameter int DIV_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [DIV_W-1:0]   div_i,
   output logic               ser_o,
   output logic               last_o
);
   localparam int BIT_W = $clog2(FRAME_W);

   logic [FRAME_W-1:0] sh_q;
   logic [DIV_W-1:0]   cnt_q;
   logic [BIT_W-1:0]   bit_q;
   logic               act_q;
   logic               bit_end;

   assign bit_end = act_q && (cnt_q == div_i);
   assign last_o  = bit_end && (bit_q == BIT_W'(FRAME_W-1));
   assign ser_o   = act_q ? sh_q[FRAME_W-1] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '1;
         cnt_q <= '0;
         bit_q <= '0;
         act_q <= 1'b0;
      end else if (load_i) begin
         sh_q  <= frame_i;
         cnt_q <= '0;
         bit_q <= '0;
         act_q <= 1'b1;
      end else if (bit_end) begin
         cnt_q <= '0;
         sh_q  <= {sh_q[FRAME_W-2:0], 1'b1};
         if (last_o) act_q <= 1'b0;
         else        bit_q <= bit_q + BIT_W'(1);
      end else if (act_q) begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/rdo_seq.sv
module rdo_seq #(
   parameter int N_SRC  = 19,
   parameter int DATA_W = 12,
   parameter int DIV_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hold_i,
   input  logic [N_SRC-1:0]           src_mask_i,
   input  logic [DIV_W-1:0]           baud_div_i,
   output logic [$clog2(N_SRC)-1:0]   mux_sel_o,
   output logic                       mux_en_o,
   output logic                       adc_start_o,
   input  logic                       adc_done_i,
   input  logic [DATA_W-1:0]          adc_data_i,
   output logic                       ser_o,
   output logic                       busy_o,
   output logic                       fe_reset_o
);
   import rdo_seq_pkg::*;

   localparam int IDX_W   = $clog2(N_SRC);
   localparam int FRAME_W = 1 + IDX_W + DATA_W + 1;

   if (N_SRC < 2 || N_SRC > 64) begin : g_bad_nsrc
      $error("rdo_seq: N_SRC out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("rdo_seq: DATA_W must be positive");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("rdo_seq: DIV_W must be positive");
   end

   seq_state_e         st_q;
   logic [N_SRC-1:0]   pend_q;
   logic [DIV_W-1:0]   div_q;
   logic [IDX_W-1:0]   idx_q;
   logic               any_pend;
   logic [IDX_W-1:0]   next_idx;
   logic [N_SRC-1:0]   next_hot;
   logic               tx_load;
   logic               tx_last;
   logic               wait_st;

   rdo_src_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .pend_i   (pend_q),
      .any_o    (any_pend),
      .idx_o    (next_idx),
      .onehot_o (next_hot)
   );

   assign wait_st = (st_q == ST_WAIT);
   assign tx_load = wait_st && adc_done_i;

   rdo_frame_tx #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tx_load),
      .frame_i ({1'b0, idx_q, adc_data_i, 1'b1}),
      .div_i   (div_q),
      .ser_o   (ser_o),
      .last_o  (tx_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= '0;
         div_q  <= '0;
         idx_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (hold_i) begin
               pend_q <= src_mask_i;
               div_q  <= baud_div_i;
               st_q   <= ST_PICK;
            end
            ST_PICK: if (any_pend) begin
               idx_q  <= next_idx;
               pend_q <= pend_q & ~next_hot;
               st_q   <= ST_START;
            end else begin
               st_q   <= ST_FIN;
            end
            ST_START: st_q <= ST_WAIT;
            ST_WAIT:  if (adc_done_i) st_q <= ST_SHIFT;
            ST_SHIFT: if (tx_last) st_q <= ST_PICK;
            ST_FIN:   st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign mux_sel_o   = idx_q;
   assign adc_start_o = (st_q == ST_START);
   assign mux_en_o    = adc_start_o || wait_st;
   assign busy_o      = (st_q != ST_IDLE);
   assign fe_reset_o  = (st_q == ST_FIN);
endmodule

// File: rtl/rdo_seq_chk.sv
module rdo_seq_chk #(
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold_i,
   input logic [IDX_W-1:0] mux_sel_o,
   input logic             mux_en_o,
   input logic             adc_start_o,
   input logic             adc_done_i,
   input logic             ser_o,
   input logic             busy_o,
   input logic             fe_reset_o,
   input logic             wait_st
);
   a_r1_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && hold_i) |=> busy_o);
   a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
      wait_st |-> ($stable(mux_sel_o) && mux_en_o));
   a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> ser_o);
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start_o |=> !adc_start_o);
   a_r8_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_st && adc_done_i) |=> !ser_o);
   a_r9_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
      fe_reset_o |-> busy_o);
   a_r9_reset_drop: assert property (@(posedge clk) disable iff (!rst_n)
      fe_reset_o |=> (!busy_o && !fe_reset_o));
endmodule

bind rdo_seq rdo_seq_chk #(.IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hold_i      (hold_i),
   .mux_sel_o   (mux_sel_o),
   .mux_en_o    (mux_en_o),
   .adc_start_o (adc_start_o),
   .adc_done_i  (adc_done_i),
   .ser_o       (ser_o),
   .busy_o      (busy_o),
   .fe_reset_o  (fe_reset_o),
   .wait_st     (wait_st)
);

// File: tb/tb_rdo_seq.sv
`timescale 1ns/1ps
module tb_rdo_seq;
   localparam int CLK_NS = 20;
   localparam int LAT    = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_i = 1'b0;
   logic [18:0] src_mask_i = '0;
   logic [7:0]  baud_div_i = '0;
   logic [4:0]  mux_sel_o;
   logic        mux_en_o, adc_start_o, ser_o, busy_o, fe_reset_o;
   logic        adc_done_i = 1'b0;
   logic [11:0] adc_data_i = '0;

   int n_cmp = 0, n_bad = 0;
   int salt = 0;
   int adc_cnt = 0, n_starts = 0, n_resets = 0, last_sel = -1;
   int sel_l = 0;
   int exp_q[$];
   int rx_b = 1;
   bit rx_on = 0;
   int rx_off = 0, rx_k = 0;
   logic [18:0] rx_bits;

   always #(CLK_NS/2) clk = ~clk;

   rdo_seq dut (.*);

   function automatic int adc_val(int s);
      return ((s * 157) ^ salt) & 12'hFFF;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural converter and line receiver, evaluated on falling edges
   always @(negedge clk) begin
      adc_done_i = 1'b0;
      if (rst_n && adc_start_o) begin
         chk(mux_en_o == 1'b1, "R3 mux_en at start", mux_en_o, 1);
         chk(int'(mux_sel_o) > last_sel, "R2 ascending order", mux_sel_o, last_sel + 1);
         last_sel = mux_sel_o;
         sel_l = mux_sel_o;
         adc_cnt = LAT;
         n_starts++;
      end else if (adc_cnt > 0) begin
         chk(int'(mux_sel_o) == sel_l, "R3 sel held", mux_sel_o, sel_l);
         adc_cnt--;
         if (adc_cnt == 0) begin
            adc_done_i = 1'b1;
            adc_data_i = 12'(adc_val(sel_l));
         end
      end
      if (rst_n && fe_reset_o) n_resets++;
      if (rst_n && !busy_o)
         chk(ser_o == 1'b1 && adc_start_o == 1'b0, "R4 idle line", ser_o, 1);
      if (rst_n && !rx_on && ser_o == 1'b0) begin
         rx_on = 1; rx_off = 0; rx_k = 0;
      end
      if (rx_on) begin
         if (rx_off == rx_k * rx_b + rx_b / 2) begin
            rx_bits[18 - rx_k] = ser_o;
            rx_k++;
            if (rx_k == 19) begin
               int e;
               rx_on = 0;
               chk(rx_bits[18] == 1'b0 && rx_bits[0] == 1'b1, "R6 start/stop", rx_bits[18], 0);
               if (exp_q.size() == 0) begin
                  chk(0, "R2 unexpected frame", {rx_bits[17:13], rx_bits[12:1]}, -1);
               end else begin
                  e = exp_q.pop_front();
                  chk(int'({rx_bits[17:13], rx_bits[12:1]}) == e, "R6 R7 frame content",
                      {rx_bits[17:13], rx_bits[12:1]}, e);
               end
            end
         end
         rx_off++;
      end
   end

   task automatic run(logic [18:0] m, int div, int s, bit retrig, bit do_lat);
      int lat = 0, pc = 0, r0, to = 0;
      salt = s;
      rx_b = div + 1;
      last_sel = -1;
      n_starts = 0;
      r0 = n_resets;
      for (int i = 0; i < 19; i++)
         if (m[i]) begin exp_q.push_back((i << 12) | adc_val(i)); pc++; end
      src_mask_i = m;
      baud_div_i = 8'(div);
      hold_i = 1'b1;
      @(negedge clk);
      hold_i = 1'b0;
      src_mask_i = ~m;          // R1 capture: later changes must not matter
      baud_div_i = 8'(div + 3); // R7 captured ratio
      chk(busy_o == 1'b1, "R1 busy after hold", busy_o, 1);
      lat = 1;
      if (do_lat) begin
         while (ser_o !== 1'b0 && lat < 200) begin @(negedge clk); lat++; end
         chk(lat == LAT + 3, "R8 first start bit latency", lat, LAT + 3);
      end
      if (retrig) begin
         repeat (5) @(negedge clk);
         src_mask_i = '1;
         hold_i = 1'b1;   // R10 hold while busy
         @(negedge clk);
         hold_i = 1'b0;
      end
      while (n_resets == r0 && to < 20000) begin @(negedge clk); to++; end
      @(negedge clk);
      chk(busy_o == 1'b0, "R9 busy low after reset", busy_o, 0);
      repeat (30) @(negedge clk);
      chk(n_resets - r0 == 1, "R9 R10 single reset", n_resets - r0, 1);
      chk(n_starts == pc, "R2 R5 conversion count", n_starts, pc);
      chk(exp_q.size() == 0, "R2 R10 all frames received", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      #(CLK_NS * 150000);
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && ser_o == 1 && fe_reset_o == 0 && adc_start_o == 0,
          "R4 reset state", {busy_o, ser_o, fe_reset_o, adc_start_o}, 4'b0100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run(19'h7FFFF, 0, 12'h000, 0, 1);   // all sources, 1-clock bits
      run(19'h40000, 3, 12'hFFF, 0, 1);   // last aux only, 4-clock bits
      run(19'h2AAAA, 1, 12'h5A5, 0, 0);   // alternate sources
      run(19'h00000, 0, 0, 0, 0);         // R9 empty mask
      run(19'h10001, 2, 12'hA5A, 1, 0);   // R10 retrigger ignored
      run(19'h00003, 0, 12'h800, 0, 1);   // adjacent low channels
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule